// File: doc/BRIEF.md
# Hotspot and Coldspot Monitor for a Processing-Element Array

This block observes the idle flags of an array of processing elements while they drain one round of work. Monitoring opens when a round-start pulse says all of the round's tasks have been dispatched. From then on a balanced voting tree ranks fixed groups of elements by how many of them report idle. The group that leads the vote in the first cycle in which any element is idle is the coldspot. The element whose idle flag comes up last, when the whole array has gone quiet, is the hotspot.

From the per-element workload counts of the finished round, the block derives how many rows should move between the hotspot and the coldspot in the next round. It scales half of the workload gap by the gap's ratio to the equal-partition workload, using shifts instead of a divider. The result is clamped to the hotspot's own load. Two slots remember the most recent pairs. When a pair recurs, its new count is averaged with the remembered one, so the amount moved settles over rounds instead of swinging back and forth. After a set number of consecutive rounds that ask for no movement, the block reports convergence and holds its outputs.

Top module: `pe_balance_monitor`

## Requirements
- R1: While no round is open, the idle flags have no effect and no result is produced. A round opens only on a `round_start` pulse.
- R2: The coldspot group is the group of GROUP_SIZE consecutive elements (element p belongs to group p / GROUP_SIZE) with the most idle flags. It is taken in the first cycle of the round in which any flag is set. `cold_id` is the lowest-indexed idle element of that group in that cycle, and flags that rise later do not change it.
- R3: When groups tie for the most idle flags, the lower-numbered group wins.
- R4: `hot_id` is the element whose idle flag rose last in the round. If several rise in that same cycle, it is the lowest-indexed of them.
- R5: `res_valid` is high for exactly one cycle, the cycle after the first cycle in which all flags are sampled set. `hot_id`, `cold_id` and `swap_rows` hold their values until the next result.
- R6: With loads taken from `pe_load` bits [p*CNT_W +: CNT_W], gap = load(hot) - load(cold), floored at 0. The estimate is gap*gap >> (floor(log2(init_load)) + 1), with an `init_load` of 0 treated as 1. `swap_rows` never exceeds load(hot).
- R7: If the new pair (hot, cold) is held in a tracking slot, the reported count is (stored count + estimate) >> 1, clamped as in R6.
- R8: Two slots hold distinct pairs. A pair equal to the current slot updates that slot's count in place. Any other pair becomes the current slot, and the old current pair moves to the previous slot. A pair in neither slot is reported as the plain estimate.
- R9: After CONV_ROUNDS consecutive results with `swap_rows` = 0, `converged` rises with that result. From then on, round starts are ignored, `res_valid` stays low and the outputs are held.
- R10: After reset all outputs are 0 and `converged` is low.
- R11: When the first idle cycle is also the cycle in which all flags are set, the coldspot and the hotspot are both taken from that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| round_start | input | 1 | Pulse: dispatch of the round is complete, monitoring opens |
| pe_empty | input | NUM_PE | Per-element idle flags, bit p for element p |
| pe_load | input | NUM_PE*CNT_W | Per-element workload counts, element p at [p*CNT_W +: CNT_W] |
| init_load | input | CNT_W | Equal-partition workload per element |
| res_valid | output | 1 | One-cycle pulse when a new result is presented |
| hot_id | output | $clog2(NUM_PE) | Element that drained last |
| cold_id | output | $clog2(NUM_PE) | Lowest idle element of the first-idle group |
| swap_rows | output | CNT_W | Rows to move between the pair next round |
| converged | output | 1 | Set after CONV_ROUNDS consecutive zero results; outputs frozen |

## Verification
The coldspot vote and the hotspot capture can fall in the same cycle when every flag rises together on the first idle cycle of a round. The bench provokes this with a round in which all drain times are equal, and with a round that has several late flags rising together. In the all-equal round, the expected coldspot comes from a vote over the full set of flags (all groups tie, so the lowest group wins) and the expected hotspot is the lowest element among those rising. The bench checks both against the single result pulse, which must appear exactly one cycle after the all-idle sample.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic [1:0] {
        MON_IDLE   = 2'd0,
        MON_WATCH  = 2'd1,
        MON_SETTLE = 2'd2
    } mon_state_e;

    // Position of the highest set bit; zero for an input of zero.
    function automatic int unsigned floor_log2(input int unsigned v);
        int unsigned r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if ((v >> i) != 0) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/pbm_vote_tree.sv
module pbm_vote_tree #(
    parameter int NUM_PE     = 8,
    parameter int GROUP_SIZE = 2,
    localparam int NUM_GRP   = NUM_PE / GROUP_SIZE,
    localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
    localparam int VCW       = $clog2(GROUP_SIZE + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PE-1:0] empty,
    output logic [GRP_W-1:0]  win_grp,
    output logic [VCW-1:0]    win_cnt
);
    // Heap-ordered tree: node n has children 2n+1 (lower groups) and 2n+2.
    localparam int NODES = 2 * NUM_GRP - 1;

    logic [GRP_W-1:0] t_idx [NODES];
    logic [VCW-1:0]   t_cnt [NODES];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_leaf
        logic [VCW-1:0] c;
        always_comb begin
            c = '0;
            for (int k = 0; k < GROUP_SIZE; k++) begin
                c = c + VCW'(empty[g*GROUP_SIZE + k]);
            end
        end
        assign t_cnt[NUM_GRP-1+g] = c;
        assign t_idx[NUM_GRP-1+g] = GRP_W'(g);
    end

    for (genvar n = 0; n < NUM_GRP - 1; n++) begin : g_node
        logic right_wins;
        // strict compare: a tie stays with the lower-indexed side
        assign right_wins = t_cnt[2*n+2] > t_cnt[2*n+1];
        assign t_cnt[n]   = right_wins ? t_cnt[2*n+2] : t_cnt[2*n+1];
        assign t_idx[n]   = right_wins ? t_idx[2*n+2] : t_idx[2*n+1];
    end

    assign win_cnt = t_cnt[0];
    assign win_grp = t_idx[0];

    function automatic logic root_is_best();
        for (int g = 0; g < NUM_GRP; g++) begin
            if (t_cnt[NUM_GRP-1+g] > win_cnt) return 1'b0;
            if (t_cnt[NUM_GRP-1+g] == win_cnt && g < int'(win_grp)) return 1'b0;
        end
        return 1'b1;
    endfunction

    // R2 / R3: root holds the largest leaf count, lowest group on a tie
    p_vote_lowest_max_r3: assert property (@(posedge clk) disable iff (rst)
        root_is_best());

endmodule

// File: rtl/pbm_drain_track.sv
module pbm_drain_track #(
    parameter int NUM_PE = 8,
    localparam int ID_W  = $clog2(NUM_PE)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              watch,
    input  logic [NUM_PE-1:0] empty,
    output logic              all_empty,
    output logic [ID_W-1:0]   hot_cand
);
    logic [NUM_PE-1:0] prev_q;
    logic [NUM_PE-1:0] rise;
    logic [ID_W-1:0]   last_q;

    function automatic logic [ID_W-1:0] lowest_set(input logic [NUM_PE-1:0] v);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = NUM_PE - 1; i >= 0; i--) begin
            if (v[i]) r = ID_W'(i);
        end
        return r;
    endfunction

    assign rise      = empty & ~prev_q;
    assign all_empty = &empty;
    assign hot_cand  = (|rise) ? lowest_set(rise) : last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            last_q <= '0;
        end else begin
            prev_q <= empty;
            if (start) begin
                last_q <= '0;
            end else if (watch && |rise) begin
                last_q <= lowest_set(rise);
            end
        end
    end

endmodule

// File: rtl/pbm_swap_calc.sv
module pbm_swap_calc
    import pbm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] load_hot,
    input  logic [CNT_W-1:0] load_cold,
    input  logic [CNT_W-1:0] init_load,
    input  logic             tracked,
    input  logic [CNT_W-1:0] stored,
    output logic [CNT_W-1:0] swap
);
    localparam int SQ_W = 2 * CNT_W;

    logic [CNT_W-1:0] gap;
    logic [SQ_W-1:0]  sq;
    logic [SQ_W-1:0]  raw;
    logic [SQ_W:0]    mixed;
    int unsigned      sh;

    always_comb begin
        gap = (load_hot > load_cold) ? (load_hot - load_cold) : '0;
        sq  = SQ_W'(gap) * SQ_W'(gap);
        // (gap/2) * (gap/init) with the divide by init replaced by a shift
        sh  = floor_log2(32'(init_load)) + 1;
        raw = sq >> sh;
        if (tracked) mixed = ({1'b0, raw} + (SQ_W+1)'(stored)) >> 1;
        else         mixed = {1'b0, raw};
        swap = (mixed > (SQ_W+1)'(load_hot)) ? load_hot : mixed[CNT_W-1:0];
    end

endmodule

// File: rtl/pe_balance_monitor.sv
module pe_balance_monitor
    import pbm_pkg::*;
#(
    parameter int NUM_PE      = 8,
    parameter int GROUP_SIZE  = 2,
    parameter int CNT_W       = 10,
    parameter int CONV_ROUNDS = 2,
    localparam int ID_W       = $clog2(NUM_PE)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    round_start,
    input  logic [NUM_PE-1:0]       pe_empty,
    input  logic [NUM_PE*CNT_W-1:0] pe_load,
    input  logic [CNT_W-1:0]        init_load,
    output logic                    res_valid,
    output logic [ID_W-1:0]         hot_id,
    output logic [ID_W-1:0]         cold_id,
    output logic [CNT_W-1:0]        swap_rows,
    output logic                    converged
);
    localparam int NUM_GRP = NUM_PE / GROUP_SIZE;
    localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int VCW     = $clog2(GROUP_SIZE + 1);
    localparam int ZC_W    = $clog2(CONV_ROUNDS + 1);

    typedef struct packed {
        logic [ID_W-1:0] hot;
        logic [ID_W-1:0] cold;
    } pair_t;

    typedef struct packed {
        logic             vld;
        pair_t            pair;
        logic [CNT_W-1:0] swap;
    } slot_t;

    mon_state_e      st_q;
    logic            cold_got_q;
    logic [ID_W-1:0] cold_q;
    logic [ID_W-1:0] hot_q;
    slot_t           cur_q;
    slot_t           prv_q;
    logic [ZC_W-1:0] zc_q;
    logic            conv_q;

    // ---------------- coldspot vote ----------------
    logic [GRP_W-1:0]  win_grp;
    logic [VCW-1:0]    win_cnt;
    logic [NUM_PE-1:0] grp_mask;
    logic [ID_W-1:0]   cold_pick;

    pbm_vote_tree #(.NUM_PE(NUM_PE), .GROUP_SIZE(GROUP_SIZE)) u_vote (
        .clk     (clk),
        .rst     (rst),
        .empty   (pe_empty),
        .win_grp (win_grp),
        .win_cnt (win_cnt)
    );

    always_comb begin
        for (int i = 0; i < NUM_PE; i++) begin
            grp_mask[i] = ((i / GROUP_SIZE) == int'(win_grp));
        end
    end

    always_comb begin
        cold_pick = '0;
        for (int i = NUM_PE - 1; i >= 0; i--) begin
            if (pe_empty[i] && grp_mask[i]) cold_pick = ID_W'(i);
        end
    end

    // ---------------- hotspot tracking ----------------
    logic            go_round;
    logic            watching;
    logic            all_empty;
    logic [ID_W-1:0] hot_cand;

    assign go_round = (st_q == MON_IDLE) && round_start && !conv_q;
    assign watching = (st_q == MON_WATCH);

    pbm_drain_track #(.NUM_PE(NUM_PE)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .start     (go_round),
        .watch     (watching),
        .empty     (pe_empty),
        .all_empty (all_empty),
        .hot_cand  (hot_cand)
    );

    // ---------------- swap amount ----------------
    pair_t            new_pair;
    logic             hit_cur;
    logic             hit_prv;
    logic [CNT_W-1:0] load_hot;
    logic [CNT_W-1:0] load_cold;
    logic [CNT_W-1:0] swap_next;

    assign new_pair  = '{hot: hot_q, cold: cold_q};
    assign hit_cur   = cur_q.vld && (cur_q.pair == new_pair);
    assign hit_prv   = prv_q.vld && (prv_q.pair == new_pair);
    assign load_hot  = pe_load[int'(hot_q)*CNT_W +: CNT_W];
    assign load_cold = pe_load[int'(cold_q)*CNT_W +: CNT_W];

    pbm_swap_calc #(.CNT_W(CNT_W)) u_calc (
        .load_hot  (load_hot),
        .load_cold (load_cold),
        .init_load (init_load),
        .tracked   (hit_cur || hit_prv),
        .stored    (hit_cur ? cur_q.swap : prv_q.swap),
        .swap      (swap_next)
    );

    // ---------------- round sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= MON_IDLE;
            cold_got_q <= 1'b0;
            cold_q     <= '0;
            hot_q      <= '0;
            cur_q      <= '0;
            prv_q      <= '0;
            zc_q       <= '0;
            conv_q     <= 1'b0;
            res_valid  <= 1'b0;
            hot_id     <= '0;
            cold_id    <= '0;
            swap_rows  <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (st_q)
                MON_IDLE: begin
                    if (go_round) begin
                        st_q       <= MON_WATCH;
                        cold_got_q <= 1'b0;
                    end
                end
                MON_WATCH: begin
                    if (!cold_got_q && win_cnt != '0) begin
                        cold_q     <= cold_pick;
                        cold_got_q <= 1'b1;
                    end
                    if (all_empty) begin
                        hot_q <= hot_cand;
                        st_q  <= MON_SETTLE;
                    end
                end
                MON_SETTLE: begin
                    res_valid <= 1'b1;
                    hot_id    <= hot_q;
                    cold_id   <= cold_q;
                    swap_rows <= swap_next;
                    if (hit_cur) begin
                        cur_q.swap <= swap_next;
                    end else begin
                        prv_q <= cur_q;
                        cur_q <= '{vld: 1'b1, pair: new_pair, swap: swap_next};
                    end
                    if (swap_next == '0) begin
                        zc_q <= zc_q + 1'b1;
                        if (zc_q == ZC_W'(CONV_ROUNDS - 1)) conv_q <= 1'b1;
                    end else begin
                        zc_q <= '0;
                    end
                    st_q <= MON_IDLE;
                end
                default: st_q <= MON_IDLE;
            endcase
        end
    end

    assign converged = conv_q;

    // ---------------- checks ----------------
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    p_result_after_settle_r1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(st_q == MON_SETTLE));

    p_swap_within_load_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (swap_rows <= pe_load[int'(hot_id)*CNT_W +: CNT_W]));

    p_slots_distinct_r8: assert property (@(posedge clk) disable iff (rst)
        (cur_q.vld && prv_q.vld) |-> (cur_q.pair != prv_q.pair));

    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        conv_q |=> (conv_q && !res_valid && $stable(hot_id)
                    && $stable(cold_id) && $stable(swap_rows)));

endmodule

// File: tb/test_pe_balance_monitor.sv
`timescale 1ns/1ps
module test_pe_balance_monitor;
    localparam int NP = 8;
    localparam int GS = 2;
    localparam int CW = 10;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          round_start = 1'b0;
    logic [NP-1:0] pe_empty = '0;
    logic [NP*CW-1:0] pe_load = '0;
    logic [CW-1:0] init_load = '0;
    logic          res_valid;
    logic [IW-1:0] hot_id;
    logic [IW-1:0] cold_id;
    logic [CW-1:0] swap_rows;
    logic          converged;

    always #2.5 clk = ~clk;

    pe_balance_monitor #(.NUM_PE(NP), .GROUP_SIZE(GS), .CNT_W(CW), .CONV_ROUNDS(2)) i_pe_balance_monitor (
        .clk(clk), .rst(rst), .round_start(round_start), .pe_empty(pe_empty),
        .pe_load(pe_load), .init_load(init_load), .res_valid(res_valid),
        .hot_id(hot_id), .cold_id(cold_id), .swap_rows(swap_rows), .converged(converged)
    );

    typedef struct {
        int    hot;
        int    cold;
        int    swap;
        string req;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // reference state
    int m_cv = 0, m_ch = 0, m_cc = 0, m_cs = 0;
    int m_pv = 0, m_ph = 0, m_pc = 0, m_ps = 0;
    int m_zc = 0, m_conv = 0;
    int l_hot = 0, l_cold = 0, l_swap = 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int flog2(input int v);
        int r = 0;
        for (int i = 0; i < 31; i++) if ((v >> i) != 0) r = i;
        return r;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (q.size() == 0) begin
                check("R1/R9 unexpected result pulse", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check({e.req, " hot_id"},    int'(hot_id),    e.hot);
                check({e.req, " cold_id"},   int'(cold_id),   e.cold);
                check({e.req, " swap_rows"}, int'(swap_rows), e.swap);
            end
        end
    end

    task automatic run_round(input string req, input int dd [NP], input int ll [NP], input int ini);
        int first, last, win, wcnt, cold, hot, gap, raw, r, sw, trk, stv, was_conv;
        int gc [NP/GS];
        exp_t e;
        first = 1000; last = 0;
        for (int p = 0; p < NP; p++) begin
            if (dd[p] < first) first = dd[p];
            if (dd[p] > last)  last  = dd[p];
        end
        for (int g = 0; g < NP/GS; g++) gc[g] = 0;
        for (int p = 0; p < NP; p++) if (dd[p] == first) gc[p/GS]++;
        win = 0; wcnt = -1;
        for (int g = 0; g < NP/GS; g++) if (gc[g] > wcnt) begin wcnt = gc[g]; win = g; end
        cold = -1;
        for (int p = NP - 1; p >= 0; p--) if (p/GS == win && dd[p] == first) cold = p;
        hot = -1;
        for (int p = NP - 1; p >= 0; p--) if (dd[p] == last) hot = p;
        gap = (ll[hot] > ll[cold]) ? ll[hot] - ll[cold] : 0;
        raw = (gap * gap) >> (flog2(ini) + 1);
        trk = 0; stv = 0;
        if (m_cv != 0 && m_ch == hot && m_cc == cold) begin trk = 1; stv = m_cs; end
        else if (m_pv != 0 && m_ph == hot && m_pc == cold) begin trk = 2; stv = m_ps; end
        r  = (trk != 0) ? (raw + stv) >> 1 : raw;
        sw = (r > ll[hot]) ? ll[hot] : r;
        was_conv = m_conv;
        if (m_conv == 0) begin
            e.hot = hot; e.cold = cold; e.swap = sw; e.req = req;
            q.push_back(e);
            if (trk == 1) m_cs = sw;
            else begin
                m_pv = m_cv; m_ph = m_ch; m_pc = m_cc; m_ps = m_cs;
                m_cv = 1; m_ch = hot; m_cc = cold; m_cs = sw;
            end
            if (sw == 0) begin m_zc++; if (m_zc >= 2) m_conv = 1; end
            else m_zc = 0;
            l_hot = hot; l_cold = cold; l_swap = sw;
        end
        // drive the round
        for (int p = 0; p < NP; p++) pe_load[p*CW +: CW] = CW'(ll[p]);
        init_load = CW'(ini);
        round_start = 1'b1;
        pe_empty = '0;
        @(negedge clk);
        round_start = 1'b0;
        for (int k = 1; k <= last; k++) begin
            for (int p = 0; p < NP; p++) pe_empty[p] = (dd[p] <= k);
            @(negedge clk);
        end
        check({req, " R5 no early pulse"}, int'(res_valid), 0);
        @(negedge clk);
        check({req, " R5 pulse one cycle after all idle"}, int'(res_valid), was_conv ? 0 : 1);
        @(negedge clk);
        check({req, " R5 pulse lasts one cycle"}, int'(res_valid), 0);
        check({req, " R5 hot_id held"}, int'(hot_id), l_hot);
        check({req, " R5 swap_rows held"}, int'(swap_rows), l_swap);
        if (was_conv != 0) check({req, " R9 cold_id frozen"}, int'(cold_id), l_cold);
        check({req, " R9 converged flag"}, int'(converged), m_conv);
        @(negedge clk);
    endtask

    initial begin
        int seen;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 res_valid after reset", int'(res_valid), 0);
        check("R10 hot_id after reset", int'(hot_id), 0);
        check("R10 cold_id after reset", int'(cold_id), 0);
        check("R10 swap_rows after reset", int'(swap_rows), 0);
        check("R10 converged after reset", int'(converged), 0);

        // R1: flags move with no round open
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            pe_empty = (i % 2 == 0) ? '1 : 8'h5A;
            @(negedge clk);
            if (res_valid) seen++;
        end
        check("R1 idle flags give no result", seen, 0);

        // R2 R4: g3 has two idle first, element 2 drains last
        run_round("R2 R4 R6 base", '{4,2,6,1,2,3,1,1}, '{8,8,20,8,8,8,8,8}, 8);
        // R7: same pair again, refined against the current slot
        run_round("R7 refine current", '{4,2,6,1,2,3,1,1}, '{8,8,24,8,8,8,8,8}, 8);
        // R3 tie between groups 1 and 2; R6 clamp with init 0
        run_round("R3 R6 tie and clamp", '{5,5,3,2,2,5,5,4}, '{30,8,8,2,8,8,8,8}, 0);
        // R8: pair held in previous slot
        run_round("R8 R7 previous slot hit", '{4,2,6,1,2,3,1,1}, '{8,8,16,8,8,8,8,8}, 8);
        run_round("R8 new pair", '{1,3,3,3,3,3,3,4}, '{6,8,8,8,8,8,8,18}, 8);
        // R8: pair dropped out of both slots, plain estimate
        run_round("R8 untracked pair", '{5,5,3,2,2,5,5,4}, '{14,8,8,2,8,8,8,8}, 16);

        // R1 again between rounds
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            pe_empty = (i % 2 == 0) ? 8'h0F : '1;
            @(negedge clk);
            if (res_valid) seen++;
        end
        check("R1 flags between rounds ignored", seen, 0);

        // R11: all flags rise in the first idle cycle
        run_round("R11 same-cycle capture", '{2,2,2,2,2,2,2,2}, '{8,8,8,8,8,8,8,8}, 8);
        run_round("R9 nonzero resets count", '{4,2,6,1,2,3,1,1}, '{8,8,20,8,8,8,8,8}, 8);
        run_round("R4 R9 zero one", '{2,1,2,2,2,2,2,2}, '{5,9,8,8,8,8,8,8}, 8);
        run_round("R11 R9 zero two", '{2,2,2,2,2,2,2,2}, '{8,8,8,8,8,8,8,8}, 8);
        // frozen: this round must give nothing
        run_round("R9 frozen round", '{4,2,6,1,2,3,1,1}, '{8,8,24,8,8,8,8,8}, 8);

        check("R9 scoreboard drained", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule